// File: doc/BRIEF.md
# External Interrupt Edge-Detect Controller

This block watches sixteen interrupt lines, each fed from one pin of several input ports. Line n can only be attached to pin n of one of the ports, and software picks which port through a 4-bit selector field. Each line watches its selected pin for rising edges, falling edges or both, under two independent enable bits. An edge on a line whose interrupt mask bit is set is latched in a pending bit. That bit drives the line's interrupt output until software clears it.

A second mask per line turns detected edges into one-cycle event pulses. These pulses never touch the pending bits. All configuration sits behind a simple word-addressed register bus: one write strobe and a combinational read. The port inputs are expected to be already synchronized to the block clock. Prioritisation and vectoring of the sixteen interrupt outputs belong to the consumer of `irq_o`.

Top module: `eint_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, and `irq_o` and `evt_o` are 0.
- R2: The selector for line n sits in the register at word address n/4, bits [4*(n%4)+3 : 4*(n%4)]. A field value p below 7 attaches line n to `port_in[p*16+n]`. A field value of 7 or more attaches a constant 0, so that line sees no edges.
- R3: With the rising-enable bit n set (address 6), a 0-to-1 change on line n's source is detected at the next clock edge.
- R4: With the falling-enable bit n set (address 7), a 1-to-0 change on line n's source is detected at the next clock edge. With that bit clear, falling edges are ignored.
- R5: With both enable bits set, either edge is detected. With neither set, the line detects nothing.
- R6: A detected edge sets pending bit n (address 8) only when interrupt-mask bit n (address 4) is 1. `irq_o[n]` is pending bit n AND mask bit n. Clearing the mask drops the output but leaves the pending bit readable.
- R7: With event-mask bit n (address 5) set, a detected edge gives `evt_o[n]` high for exactly the one cycle after the detecting clock edge. Events never set pending bits.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An edge detected in the same cycle as the clear leaves the bit set.
- R9: Writing a selector register reloads the edge reference of each line in it from the newly selected source. Changing source therefore reports no edge even when the old and new pins differ in level.
- R10: Registers read back the written values in their low 16 bits. Bits 31:16 always read 0, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| port_in | input | 112 | Synchronized port pins, port p pin n at bit p*16+n |
| irq_o | output | 16 | Per-line interrupt level |
| evt_o | output | 16 | Per-line one-cycle event pulse |

## Verification
An input change applied before a clock edge is seen at that edge, so the pending bit, `irq_o` and `evt_o` all move one edge later. A register write takes effect at the same edge, and a read returns data combinationally in the cycle the address is presented. The bench therefore drives pins and bus writes just after a falling edge and checks the outputs at the following falling edge. It checks reads one time unit after setting the address, with no clock edge in between. A per-cycle model applies the requirements to each step, including reference reloads on selector writes and clear-versus-set collisions on the pending bits.

// File: rtl/eint_pkg.sv
// Shared definitions for the external interrupt controller.
// Assumes the register map: selector words first, then five line-vector words.
package eint_pkg;

    // Kind of register addressed on the bus
    typedef enum logic [2:0] {
        K_SEL,
        K_IMASK,
        K_EMASK,
        K_RISE,
        K_FALL,
        K_PEND,
        K_NONE
    } reg_kind_e;

    // Map a word address to the register kind it selects
    function automatic reg_kind_e decode_kind(input int unsigned addr, input int unsigned n_sel);
        if (addr < n_sel) return K_SEL;
        case (addr - n_sel)
            0:       return K_IMASK;
            1:       return K_EMASK;
            2:       return K_RISE;
            3:       return K_FALL;
            4:       return K_PEND;
            default: return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/eint_regs.sv
// Register file of the interrupt controller: selector fields, the four
// per-line configuration vectors and the write-one-to-clear pending vector.
// Assumes N_LINES and LINES_PER_SEL*SEL_W both fit in DATA_W.
module eint_regs
    import eint_pkg::*;
#(
    parameter int N_LINES       = 16,
    parameter int SEL_W         = 4,
    parameter int LINES_PER_SEL = 4,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [N_LINES-1:0]       pend_set,
    output logic [N_LINES*SEL_W-1:0] sel_field,
    output logic [N_LINES-1:0]       sel_load,
    output logic [N_LINES*SEL_W-1:0] sel_next,
    output logic [N_LINES-1:0]       imask_o,
    output logic [N_LINES-1:0]       emask_o,
    output logic [N_LINES-1:0]       rise_o,
    output logic [N_LINES-1:0]       fall_o,
    output logic [N_LINES-1:0]       pend_o
);
    localparam int N_SEL_REGS = N_LINES / LINES_PER_SEL;
    localparam int SEL_BITS   = LINES_PER_SEL * SEL_W;
    localparam int USED_W     = (SEL_BITS > N_LINES) ? SEL_BITS : N_LINES;

    reg_kind_e          kind;
    logic [N_LINES-1:0] imask_q, emask_q, rise_q, fall_q, pend_q, clr_mask;

    // Decode which register the bus address selects
    always_comb kind = decode_kind(32'(bus_addr), N_SEL_REGS);

    // Bits of the write data beyond the used width are dropped
    generate
        if (DATA_W > USED_W) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[DATA_W-1:USED_W];
        end
    endgenerate

    // One selector field per line, placed in word n/LINES_PER_SEL
    generate
        for (genvar n = 0; n < N_LINES; n++) begin : g_sel
            localparam logic [ADDR_W-1:0] HOME = ADDR_W'(n / LINES_PER_SEL);
            localparam int                OFS  = (n % LINES_PER_SEL) * SEL_W;
            logic [SEL_W-1:0] field_q;

            assign sel_load[n]                  = bus_wr && (kind == K_SEL) && (bus_addr == HOME);
            assign sel_next[n*SEL_W +: SEL_W]   = bus_wdata[OFS +: SEL_W];
            assign sel_field[n*SEL_W +: SEL_W]  = field_q;

            // Hold the selector field, loading it on a write to its word
            always_ff @(posedge clk) begin
                if (!rst_n)          field_q <= '0;
                else if (sel_load[n]) field_q <= bus_wdata[OFS +: SEL_W];
            end
        end
    endgenerate

    // Hold the mask and trigger-enable vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= '0;
            emask_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else if (bus_wr) begin
            case (kind)
                K_IMASK: imask_q <= bus_wdata[N_LINES-1:0];
                K_EMASK: emask_q <= bus_wdata[N_LINES-1:0];
                K_RISE:  rise_q  <= bus_wdata[N_LINES-1:0];
                K_FALL:  fall_q  <= bus_wdata[N_LINES-1:0];
                default: ;
            endcase
        end
    end

    // Bits software asks to clear this cycle
    always_comb clr_mask = (bus_wr && (kind == K_PEND)) ? bus_wdata[N_LINES-1:0] : '0;

    // Pending vector: new requests win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | pend_set;
    end

    // Combinational read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (kind)
            K_SEL: begin
                for (int i = 0; i < N_LINES; i++) begin
                    if (int'(bus_addr) == i / LINES_PER_SEL)
                        bus_rdata[(i % LINES_PER_SEL)*SEL_W +: SEL_W] = sel_field[i*SEL_W +: SEL_W];
                end
            end
            K_IMASK: bus_rdata[N_LINES-1:0] = imask_q;
            K_EMASK: bus_rdata[N_LINES-1:0] = emask_q;
            K_RISE:  bus_rdata[N_LINES-1:0] = rise_q;
            K_FALL:  bus_rdata[N_LINES-1:0] = fall_q;
            K_PEND:  bus_rdata[N_LINES-1:0] = pend_q;
            default: ;
        endcase
    end

    assign imask_o = imask_q;
    assign emask_o = emask_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;
    assign pend_o  = pend_q;

endmodule

// File: rtl/eint_line.sv
// One interrupt line: picks its source pin among the ports and compares it
// with the value seen one clock earlier to find enabled edges.
// Assumes pins are synchronous to clk; selector values >= N_PORTS give 0.
module eint_line #(
    parameter int N_PORTS = 7,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] pins,
    input  logic [SEL_W-1:0]   sel,
    input  logic               sel_load,
    input  logic [SEL_W-1:0]   sel_next,
    input  logic               rise_en,
    input  logic               fall_en,
    output logic               hit
);
    logic cur_lvl, next_lvl, prev_q;

    // Level of the currently selected source
    always_comb begin
        cur_lvl = 1'b0;
        for (int p = 0; p < N_PORTS; p++)
            if (sel == SEL_W'(p)) cur_lvl = pins[p];
    end

    // Level of the source about to be selected by a bus write
    always_comb begin
        next_lvl = 1'b0;
        for (int p = 0; p < N_PORTS; p++)
            if (sel_next == SEL_W'(p)) next_lvl = pins[p];
    end

    // Edge reference: follows the source, or reloads from the new one
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (sel_load) prev_q <= next_lvl;
        else               prev_q <= cur_lvl;
    end

    // Report an enabled edge
    always_comb hit = (rise_en & cur_lvl & ~prev_q) | (fall_en & ~cur_lvl & prev_q);

endmodule

// File: rtl/eint_ctrl.sv
// Top of the external interrupt controller: register file, one edge
// detector per line, interrupt level outputs and event pulses.
// Assumes port_in is already synchronized; port p pin n is bit p*N_LINES+n.
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int N_LINES       = 16,
    parameter int N_PORTS       = 7,
    parameter int SEL_W         = 4,
    parameter int LINES_PER_SEL = 4,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [N_PORTS*N_LINES-1:0] port_in,
    output logic [N_LINES-1:0]         irq_o,
    output logic [N_LINES-1:0]         evt_o
);
    localparam int N_SEL_REGS = N_LINES / LINES_PER_SEL;

    logic [N_LINES*SEL_W-1:0] sel_field, sel_next;
    logic [N_LINES-1:0]       sel_load, imask, emask, rise_en, fall_en, pend;
    logic [N_LINES-1:0]       hit, evt_q;

    eint_regs #(
        .N_LINES(N_LINES), .SEL_W(SEL_W), .LINES_PER_SEL(LINES_PER_SEL),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_set(hit & imask),
        .sel_field(sel_field), .sel_load(sel_load), .sel_next(sel_next),
        .imask_o(imask), .emask_o(emask), .rise_o(rise_en), .fall_o(fall_en), .pend_o(pend)
    );

    // One edge detector per line, fed with pin n of every port
    generate
        for (genvar n = 0; n < N_LINES; n++) begin : g_line
            logic [N_PORTS-1:0] line_pins;
            for (genvar p = 0; p < N_PORTS; p++) begin : g_pin
                assign line_pins[p] = port_in[p*N_LINES + n];
            end
            eint_line #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_line (
                .clk(clk), .rst_n(rst_n),
                .pins(line_pins),
                .sel(sel_field[n*SEL_W +: SEL_W]),
                .sel_load(sel_load[n]),
                .sel_next(sel_next[n*SEL_W +: SEL_W]),
                .rise_en(rise_en[n]), .fall_en(fall_en[n]),
                .hit(hit[n])
            );
        end
    endgenerate

    // Event pulses: one cycle per detected edge, gated by the event mask
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= hit & emask;
    end

    assign evt_o = evt_q;
    assign irq_o = pend & imask;

endmodule

// File: rtl/eint_ctrl_chk.sv
// Property checker for eint_ctrl, attached with bind below.
// Assumes reset is held low from time zero until after the first clock edge.
module eint_ctrl_chk #(
    parameter int N_LINES   = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int USED_W    = 16,
    parameter int PEND_ADDR = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [N_LINES-1:0] imask,
    input logic [N_LINES-1:0] emask,
    input logic [N_LINES-1:0] rise_en,
    input logic [N_LINES-1:0] fall_en,
    input logic [N_LINES-1:0] pend,
    input logic [N_LINES-1:0] irq_o,
    input logic [N_LINES-1:0] evt_o
);
    logic               was_rst;
    logic [N_LINES-1:0] clr_seen;

    // Remember that the previous edge was in reset
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Bits the bus asked to clear this cycle
    always_comb clr_seen = (bus_wr && (bus_addr == ADDR_W'(PEND_ADDR))) ? bus_wdata[N_LINES-1:0] : '0;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (irq_o == '0 && evt_o == '0));

    assert_new_pend_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~($past(rise_en) | $past(fall_en))) == '0);

    assert_evt_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~($past(rise_en) | $past(fall_en))) == '0);

    assert_new_pend_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~$past(imask)) == '0);

    assert_evt_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~$past(emask)) == '0);

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~pend & ~$past(clr_seen)) == '0);

    assert_rdata_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:USED_W] == '0);

endmodule

bind eint_ctrl eint_ctrl_chk #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .USED_W((LINES_PER_SEL*SEL_W > N_LINES) ? LINES_PER_SEL*SEL_W : N_LINES),
    .PEND_ADDR(N_SEL_REGS + 4)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .imask(imask), .emask(emask), .rise_en(rise_en), .fall_en(fall_en),
    .pend(pend), .irq_o(irq_o), .evt_o(evt_o)
);

// File: tb/test_eint_ctrl.sv
// Bench for eint_ctrl: directed corner cases, then seeded random stimulus,
// all compared with a per-cycle model built from the requirements.
module test_eint_ctrl;
    localparam int NL = 16, NP = 7, SW = 4, LPS = 4, DW = 32, AW = 4, NSR = 4;
    localparam int PW = NP * NL;
    localparam int A_IM = 4, A_EM = 5, A_RI = 6, A_FA = 7, A_PE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [PW-1:0] port_in = '0;
    logic [NL-1:0] irq_o, evt_o;

    always #5 clk = ~clk;

    eint_ctrl i_eint_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_in(port_in),
        .irq_o(irq_o), .evt_o(evt_o)
    );

    // Model state
    logic [SW-1:0] m_sel [NL];
    logic [NL-1:0] m_im, m_em, m_ri, m_fa, m_pe, m_prev, x_irq, x_evt;
    logic [PW-1:0] pv;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Source level of line n for selector s (R2)
    function automatic logic pick(input logic [SW-1:0] s, input logic [PW-1:0] v, input int n);
        if (int'(s) < NP) return v[int'(s)*NL + n];
        return 1'b0;
    endfunction

    // Expected read data (R10: upper bits zero)
    function automatic logic [DW-1:0] mread(input int a);
        logic [DW-1:0] r = '0;
        if (a < NSR) begin
            for (int i = 0; i < LPS; i++) r[i*SW +: SW] = m_sel[a*LPS + i];
        end else begin
            case (a)
                A_IM: r[NL-1:0] = m_im;
                A_EM: r[NL-1:0] = m_em;
                A_RI: r[NL-1:0] = m_ri;
                A_FA: r[NL-1:0] = m_fa;
                A_PE: r[NL-1:0] = m_pe;
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, check irq and events
    task automatic step(input logic wr, input int a, input logic [DW-1:0] d, input string tag);
        logic [NL-1:0] hit, clr;
        logic c;
        port_in = pv; bus_wr = wr; bus_addr = a[AW-1:0]; bus_wdata = d;
        for (int n = 0; n < NL; n++) begin
            c = pick(m_sel[n], pv, n);
            hit[n] = (m_ri[n] & c & ~m_prev[n]) | (m_fa[n] & ~c & m_prev[n]);
            if (wr && a == n / LPS) m_prev[n] = pick(d[(n % LPS)*SW +: SW], pv, n);
            else                    m_prev[n] = c;
        end
        clr   = (wr && a == A_PE) ? d[NL-1:0] : '0;
        x_evt = hit & m_em;
        m_pe  = (m_pe & ~clr) | (hit & m_im);
        if (wr) begin
            if (a < NSR) begin
                for (int i = 0; i < LPS; i++) m_sel[a*LPS + i] = d[i*SW +: SW];
            end else begin
                case (a)
                    A_IM: m_im = d[NL-1:0];
                    A_EM: m_em = d[NL-1:0];
                    A_RI: m_ri = d[NL-1:0];
                    A_FA: m_fa = d[NL-1:0];
                    default: ;
                endcase
            end
        end
        x_irq = m_pe & m_im;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        chk({tag, " irq"}, DW'(irq_o), DW'(x_irq));
        chk({tag, " evt"}, DW'(evt_o), DW'(x_evt));
    endtask

    task automatic rd(input int a, input string tag);
        bus_wr = 1'b0;
        bus_addr = a[AW-1:0];
        #1;
        chk({tag, " read"}, bus_rdata, mread(a));
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, '0, tag);
    endtask

    initial begin
        for (int n = 0; n < NL; n++) m_sel[n] = '0;
        m_im = '0; m_em = '0; m_ri = '0; m_fa = '0; m_pe = '0; m_prev = '0;
        pv = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= A_PE; a++) rd(a, "R1");
        chk("R1 irq", DW'(irq_o), '0);
        chk("R1 evt", DW'(evt_o), '0);

        // R10: readback and dropped upper bits
        step(1'b1, A_IM, 32'hFFFF_A5C3, "R10");
        rd(A_IM, "R10");
        step(1'b1, 2, 32'hDEAD_7654, "R10");
        rd(2, "R10");
        step(1'b1, A_IM, '0, "R10");
        step(1'b1, 2, '0, "R10");

        // R2: line 5 on port 3
        step(1'b1, 1, 32'h30, "R2");
        step(1'b1, A_RI, 32'h20, "R2");
        step(1'b1, A_IM, 32'h20, "R2");
        pv[0*NL + 5] = 1'b1; step(1'b0, 0, '0, "R2 other port");
        pv[3*NL + 5] = 1'b1; step(1'b0, 0, '0, "R2 selected port");
        rd(A_PE, "R2");
        step(1'b1, A_PE, 32'h20, "R8 clear");
        rd(A_PE, "R8");
        // R2: out-of-range selector sees nothing
        step(1'b1, 1, 32'h90, "R2 out of range");
        for (int p = 0; p < NP; p++) pv[p*NL + 5] = 1'b0;
        idle("R2 out of range fall");
        for (int p = 0; p < NP; p++) pv[p*NL + 5] = 1'b1;
        idle("R2 out of range rise");
        rd(A_PE, "R2");
        step(1'b1, 1, '0, "R2");

        // R3: rising only on line 0
        step(1'b1, A_RI, 32'h1, "R3");
        step(1'b1, A_IM, 32'h1, "R3");
        pv[0] = 1'b1; idle("R3 rise");
        step(1'b1, A_PE, 32'h1, "R3");
        pv[0] = 1'b0; idle("R3 fall ignored");
        rd(A_PE, "R3");
        // R4: falling only
        step(1'b1, A_RI, '0, "R4");
        step(1'b1, A_FA, 32'h1, "R4");
        pv[0] = 1'b1; idle("R4 rise ignored");
        pv[0] = 1'b0; idle("R4 fall");
        step(1'b1, A_PE, 32'h1, "R4");
        // R5: both edges
        step(1'b1, A_RI, 32'h1, "R5");
        pv[0] = 1'b1; idle("R5 rise");
        step(1'b1, A_PE, 32'h1, "R5");
        pv[0] = 1'b0; idle("R5 fall");
        rd(A_PE, "R5");

        // R6: mask off with pending set, then edge while masked
        step(1'b1, A_IM, '0, "R6 mask off");
        rd(A_PE, "R6");
        step(1'b1, A_PE, 32'h1, "R6");
        pv[0] = 1'b1; idle("R6 masked edge");
        rd(A_PE, "R6");

        // R7: event only, no pending
        step(1'b1, A_EM, 32'h1, "R7");
        pv[0] = 1'b0; idle("R7 event");
        idle("R7 event ends");
        rd(A_PE, "R7");

        // R8: clear collides with new edge; write of 0 is harmless
        step(1'b1, A_IM, 32'h1, "R8");
        pv[0] = 1'b1; idle("R8 set");
        pv[0] = 1'b0; step(1'b1, A_PE, 32'h1, "R8 collision");
        rd(A_PE, "R8");
        step(1'b1, A_PE, '0, "R8 write zero");
        rd(A_PE, "R8");
        step(1'b1, A_PE, 32'hFFFF, "R8");

        // R9: source change gives no false edge on line 1
        step(1'b1, A_RI, 32'h2, "R9");
        step(1'b1, A_FA, 32'h2, "R9");
        step(1'b1, A_IM, 32'h2, "R9");
        pv[2*NL + 1] = 1'b1; idle("R9");
        step(1'b1, 0, 32'h20, "R9 switch to high pin");
        idle("R9 after switch");
        step(1'b1, 0, 32'h00, "R9 switch to low pin");
        idle("R9 after switch back");
        rd(A_PE, "R9");

        // Random phase
        for (int k = 0; k < 600; k++) begin
            int ai;
            logic [DW-1:0] dd;
            pv = pv ^ (PW'(1) << ($urandom % PW));
            if ($urandom % 2 == 0) pv = pv ^ (PW'(1) << ($urandom % PW));
            ai = int'($urandom % 9);
            dd = $urandom;
            if ($urandom % 4 == 0) step(1'b1, ai, dd, "R6 random");
            else                   idle("R7 random");
            if (k % 16 == 0) rd(A_PE, "R8 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule